// File: doc/BRIEF.md
# Clock-Phase-Gated Control Line Driver

This block is the last stage of a microcoded control unit. It takes the control word produced by microcode storage and places it on a set of shared backplane control lines. Those lines have pull-ups. The block drives the lines only while the system clock is low. Whenever the clock is high, every line it owns is left at high impedance. That makes the clock-high phase both a settling window and a bus-release window. While microcode storage outputs are still settling, nothing is driven. During the same window an external debugger may drive the lines itself without contention.

The word is captured on the falling clock edge, so the lines hold one steady value for the whole low phase. Each line is chosen so that a released, pulled-up bus means "do nothing". Single-bit strobes are active-low, and every encoded command field keeps its all-ones code as no-op. On the way through, the block cleans two hazards out of the word:

- Reserved program-counter operation codes are turned into the no-op code.
- A register-load strobe aimed at the index that holds the program counter is suppressed, because that slot cannot be loaded through the register path.

The status output `bus_oe` tells external logic whether the block is driving the lines.

Top module: `ctlbus_phase_driver`

## Requirements
- R1: While `clk` is high, `bus_oe` is 0 and every control output is high impedance, so each line reads 1 through its pull-up when no other agent drives it.
- R2: While `clk` is low and the block is out of reset, `bus_oe` is 1. The lines carry the control word sampled at the most recent falling edge, after the clean-up of R5 and R6, with `reg_idx_o` and `src_sel_o` equal to the sampled inputs.
- R3: The control word is sampled only at the falling edge of `clk`. A change of the microcode inputs during the low phase does not reach the lines until the next falling edge.
- R4: Strobe lines `strobe_n_o` use active-low polarity: 0 means asserted and 1 means idle. Each bit is passed through unchanged from `mc_strobe_n`.
- R5: Program-counter operation field: codes 0 to 4 are load operations and pass unchanged. Code 7 (all ones) is the no-op and passes unchanged. Reserved codes 5 and 6 are replaced by 7.
- R6: When the sampled register index equals 14, `reg_ld_n_o` is driven 1 (idle) whatever `mc_reg_ld_n` requests. For any other index, `mc_reg_ld_n` is passed unchanged.
- R7: Reset is synchronous and active high, sampled at the falling edge. After a falling edge with `rst` high, `bus_oe` stays 0 through the following low phase and all lines read 1.
- R8: During the clock-high phase an external agent driving the lines sees exactly its own values on them, because the block drives nothing.
- R9: `bus_oe` is 1 exactly in the low phases in which the block drives the lines, starting with the first low phase after a falling edge that sampled `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; high phase releases the bus, low phase drives it |
| rst | input | 1 | Synchronous active-high reset, sampled at the falling edge |
| mc_strobe_n | input | 8 | Active-low strobes from microcode storage |
| mc_reg_ld_n | input | 1 | Active-low register-load strobe from microcode storage |
| mc_reg_idx | input | 4 | Register index field from microcode storage |
| mc_pc_op | input | 3 | Program-counter operation code from microcode storage |
| mc_src_sel | input | 3 | Bus source select field from microcode storage (7 = no-op) |
| strobe_n_o | output | 8 | Tri-state active-low strobe lines |
| reg_ld_n_o | output | 1 | Tri-state active-low register-load line |
| reg_idx_o | output | 4 | Tri-state register index lines |
| pc_op_o | output | 3 | Tri-state program-counter operation lines |
| src_sel_o | output | 3 | Tri-state source select lines |
| bus_oe | output | 1 | High when the block is driving the control lines |

## Verification
A wrong capture register or a wrong enable appears at the lines within half a clock period. If the output enable is stuck on during a high phase, the pull-up level and the values driven by the test debugger are corrupted at the next high-phase sample. If the enable is stuck off, the word is lost in the very next low phase. If the capture register samples on the wrong edge, or is transparent, a mid-low-phase change of the inputs shows up at the low-phase sample of that same cycle. An error in the clean-up logic shows at the low-phase sample of the cycle in which a reserved code or index 14 was presented.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

    parameter int STB_W   = 8;
    parameter int IDX_W   = 4;
    parameter int PCOP_W  = 3;
    parameter int SRC_W   = 3;
    parameter int PC_SLOT = 14;
    parameter int PCOP_LOADS = 5;

    localparam logic [PCOP_W-1:0] PCOP_NOP = '1;
    localparam logic [SRC_W-1:0]  SRC_NOP  = '1;

    typedef struct packed {
        logic [STB_W-1:0]  strobe_n;
        logic              reg_ld_n;
        logic [IDX_W-1:0]  reg_idx;
        logic [PCOP_W-1:0] pc_op;
        logic [SRC_W-1:0]  src_sel;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '{
        strobe_n: '1,
        reg_ld_n: 1'b1,
        reg_idx:  '1,
        pc_op:    PCOP_NOP,
        src_sel:  SRC_NOP
    };

    function automatic logic pcop_is_legal(input logic [PCOP_W-1:0] code);
        return (int'(code) < PCOP_LOADS) || (code == PCOP_NOP);
    endfunction

endpackage

// File: rtl/ctl_word_sanitize.sv
module ctl_word_sanitize
    import ctlbus_pkg::*;
(
    input  ctl_word_t raw_i,
    output ctl_word_t clean_o
);

    logic idx_hits_pc;

    assign idx_hits_pc = (raw_i.reg_idx == IDX_W'(PC_SLOT));

    always_comb begin
        clean_o = raw_i;
        if (!pcop_is_legal(raw_i.pc_op)) begin
            clean_o.pc_op = PCOP_NOP;
        end
        if (idx_hits_pc) begin
            clean_o.reg_ld_n = 1'b1;
        end
    end

endmodule

// File: rtl/ctl_fall_capture.sv
module ctl_fall_capture
    import ctlbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_word_t word_i,
    output ctl_word_t held_o,
    output logic      drive_en_o
);

    always_ff @(negedge clk) begin
        if (rst) begin
            held_o     <= CTL_IDLE;
            drive_en_o <= 1'b0;
        end else begin
            held_o     <= word_i;
            drive_en_o <= 1'b1;
        end
    end

endmodule

// File: rtl/ctlbus_phase_driver.sv
module ctlbus_phase_driver
    import ctlbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STB_W-1:0]  mc_strobe_n,
    input  logic              mc_reg_ld_n,
    input  logic [IDX_W-1:0]  mc_reg_idx,
    input  logic [PCOP_W-1:0] mc_pc_op,
    input  logic [SRC_W-1:0]  mc_src_sel,
    output wire  [STB_W-1:0]  strobe_n_o,
    output wire               reg_ld_n_o,
    output wire  [IDX_W-1:0]  reg_idx_o,
    output wire  [PCOP_W-1:0] pc_op_o,
    output wire  [SRC_W-1:0]  src_sel_o,
    output logic              bus_oe
);

    ctl_word_t raw_word;
    ctl_word_t clean_word;
    ctl_word_t held_word;
    logic      drive_en;

    assign raw_word = '{
        strobe_n: mc_strobe_n,
        reg_ld_n: mc_reg_ld_n,
        reg_idx:  mc_reg_idx,
        pc_op:    mc_pc_op,
        src_sel:  mc_src_sel
    };

    ctl_word_sanitize u_sanitize (
        .raw_i   (raw_word),
        .clean_o (clean_word)
    );

    ctl_fall_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .word_i     (clean_word),
        .held_o     (held_word),
        .drive_en_o (drive_en)
    );

    // Lines are only driven in the low phase of an enabled cycle.
    assign bus_oe = drive_en & ~clk;

    assign strobe_n_o = bus_oe ? held_word.strobe_n : {STB_W{1'bz}};
    assign reg_ld_n_o = bus_oe ? held_word.reg_ld_n : 1'bz;
    assign reg_idx_o  = bus_oe ? held_word.reg_idx  : {IDX_W{1'bz}};
    assign pc_op_o    = bus_oe ? held_word.pc_op    : {PCOP_W{1'bz}};
    assign src_sel_o  = bus_oe ? held_word.src_sel  : {SRC_W{1'bz}};

endmodule

// File: rtl/ctlbus_phase_driver_chk.sv
module ctlbus_phase_driver_chk
    import ctlbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_oe,
    input logic              reg_ld_n_o,
    input logic [IDX_W-1:0]  reg_idx_o,
    input logic [PCOP_W-1:0] pc_op_o
);

    AST_RELEASE_HIGH_PHASE: assert property (@(negedge clk) !bus_oe); // R1

    AST_RESET_KEEPS_RELEASED: assert property (@(posedge clk) rst |-> !bus_oe); // R7

    AST_DRIVE_LOW_PHASE: assert property (@(posedge clk) disable iff (rst) bus_oe); // R9

    AST_PCOP_LEGAL_ON_BUS: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (int'(pc_op_o) < PCOP_LOADS || pc_op_o == PCOP_NOP)); // R5

    AST_PC_SLOT_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && reg_idx_o == IDX_W'(PC_SLOT)) |-> reg_ld_n_o); // R6

endmodule

bind ctlbus_phase_driver ctlbus_phase_driver_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_oe     (bus_oe),
    .reg_ld_n_o (reg_ld_n_o),
    .reg_idx_o  (reg_idx_o),
    .pc_op_o    (pc_op_o)
);

// File: tb/tb_ctlbus_phase_driver.sv
`timescale 1ns/100ps
module tb_ctlbus_phase_driver;

    logic       clk = 1'b1;
    logic       rst = 1'b1;
    logic [7:0] mc_strobe_n = '1;
    logic       mc_reg_ld_n = 1'b1;
    logic [3:0] mc_reg_idx  = '0;
    logic [2:0] mc_pc_op    = 3'd7;
    logic [2:0] mc_src_sel  = 3'd7;

    tri1 [7:0] strobe_w;
    tri1       ld_w;
    tri1 [3:0] idx_w;
    tri1 [2:0] pc_w;
    tri1 [2:0] src_w;
    logic      bus_oe;

    logic       dbg_en = 1'b0;
    logic [7:0] dbg_strobe = '0;
    logic       dbg_ld = 1'b0;
    logic [3:0] dbg_idx = '0;
    logic [2:0] dbg_pc = '0;
    logic [2:0] dbg_src = '0;

    assign strobe_w = dbg_en ? dbg_strobe : 8'bz;
    assign ld_w     = dbg_en ? dbg_ld     : 1'bz;
    assign idx_w    = dbg_en ? dbg_idx    : 4'bz;
    assign pc_w     = dbg_en ? dbg_pc     : 3'bz;
    assign src_w    = dbg_en ? dbg_src    : 3'bz;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit         m_oe = 1'b0;
    logic [7:0] m_strobe = '1;
    logic       m_ld = 1'b1;
    logic [3:0] m_idx = '1;
    logic [2:0] m_pc = 3'd7;
    logic [2:0] m_src = 3'd7;

    always #2 clk = ~clk;

    ctlbus_phase_driver dut (
        .clk         (clk),
        .rst         (rst),
        .mc_strobe_n (mc_strobe_n),
        .mc_reg_ld_n (mc_reg_ld_n),
        .mc_reg_idx  (mc_reg_idx),
        .mc_pc_op    (mc_pc_op),
        .mc_src_sel  (mc_src_sel),
        .strobe_n_o  (strobe_w),
        .reg_ld_n_o  (ld_w),
        .reg_idx_o   (idx_w),
        .pc_op_o     (pc_w),
        .src_sel_o   (src_w),
        .bus_oe      (bus_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input bit r, input logic [7:0] s, input logic ld,
                             input logic [3:0] idx, input logic [2:0] pc,
                             input logic [2:0] src, input bit dbg, input bit glitch);
        string ht;
        @(posedge clk);
        #0.5;
        rst = r;
        mc_strobe_n = s; mc_reg_ld_n = ld; mc_reg_idx = idx;
        mc_pc_op = pc; mc_src_sel = src;
        if (dbg) begin
            dbg_strobe = 8'($urandom); dbg_ld = 1'($urandom);
            dbg_idx = 4'($urandom); dbg_pc = 3'($urandom); dbg_src = 3'($urandom);
            dbg_en = 1'b1;
        end
        #0.9;
        // high phase: block released
        ht = dbg ? "R8" : "R1";
        chk("R1", "bus_oe high phase", 32'(bus_oe), 32'd0);
        chk(ht, "strobe high phase", 32'(strobe_w), dbg ? 32'(dbg_strobe) : 32'hff);
        chk(ht, "ld high phase",     32'(ld_w),     dbg ? 32'(dbg_ld)     : 32'h1);
        chk(ht, "idx high phase",    32'(idx_w),    dbg ? 32'(dbg_idx)    : 32'hf);
        chk(ht, "pc high phase",     32'(pc_w),     dbg ? 32'(dbg_pc)     : 32'h7);
        chk(ht, "src high phase",    32'(src_w),    dbg ? 32'(dbg_src)    : 32'h7);
        #0.3;
        dbg_en = 1'b0;
        @(negedge clk);
        if (rst) begin
            m_oe = 1'b0;
        end else begin
            m_oe     = 1'b1;
            m_strobe = mc_strobe_n;
            m_idx    = mc_reg_idx;
            m_src    = mc_src_sel;
            m_pc     = (mc_pc_op == 3'd5 || mc_pc_op == 3'd6) ? 3'd7 : mc_pc_op;
            m_ld     = (mc_reg_idx == 4'd14) ? 1'b1 : mc_reg_ld_n;
        end
        #1.0;
        if (glitch) begin
            mc_strobe_n = ~s; mc_reg_ld_n = ~ld; mc_reg_idx = ~idx;
            mc_pc_op = ~pc; mc_src_sel = ~src;
        end
        #0.5;
        // low phase
        if (m_oe) begin
            chk("R9", "bus_oe low phase", 32'(bus_oe), 32'd1);
            chk(glitch ? "R3" : "R4", "strobe low phase", 32'(strobe_w), 32'(m_strobe));
            chk(glitch ? "R3" : "R6", "ld low phase",     32'(ld_w),     32'(m_ld));
            chk(glitch ? "R3" : "R2", "idx low phase",    32'(idx_w),    32'(m_idx));
            chk(glitch ? "R3" : "R5", "pc low phase",     32'(pc_w),     32'(m_pc));
            chk(glitch ? "R3" : "R2", "src low phase",    32'(src_w),    32'(m_src));
        end else begin
            chk("R7", "bus_oe in reset",  32'(bus_oe),   32'd0);
            chk("R7", "strobe in reset",  32'(strobe_w), 32'hff);
            chk("R7", "ld in reset",      32'(ld_w),     32'h1);
            chk("R7", "pc in reset",      32'(pc_w),     32'h7);
            chk("R7", "src in reset",     32'(src_w),    32'h7);
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // reset, with inputs asking for activity
        for (int i = 0; i < 3; i++) run_cycle(1, 8'h00, 0, 4'd3, 3'd0, 3'd1, 0, 0);
        run_cycle(1, 8'h00, 0, 4'd3, 3'd0, 3'd1, 1, 0);
        // idle word
        run_cycle(0, 8'hff, 1, 4'd0, 3'd7, 3'd7, 0, 0);
        // walking-zero strobes (R4)
        for (int b = 0; b < 8; b++) run_cycle(0, ~(8'h1 << b), 1, 4'd2, 3'd7, 3'd7, 0, 0);
        // every pc op code (R5)
        for (int c = 0; c < 8; c++) run_cycle(0, 8'hff, 1, 4'd1, 3'(c), 3'(c), 0, 0);
        // register index corner cases (R6)
        run_cycle(0, 8'hff, 0, 4'd14, 3'd7, 3'd7, 0, 0);
        run_cycle(0, 8'hff, 1, 4'd14, 3'd7, 3'd7, 0, 0);
        run_cycle(0, 8'hff, 0, 4'd13, 3'd7, 3'd7, 0, 0);
        run_cycle(0, 8'hff, 0, 4'd15, 3'd7, 3'd7, 0, 0);
        // debugger override on high phase (R8) and mid-low changes (R3)
        for (int i = 0; i < 6; i++) run_cycle(0, 8'h5a, 0, 4'd6, 3'd2, 3'd3, 1, 1);
        // mixed random traffic
        for (int i = 0; i < 200; i++)
            run_cycle(0, 8'($urandom), 1'($urandom), 4'($urandom), 3'($urandom),
                      3'($urandom), 1'($urandom), 1'($urandom));
        // reset again in mid-run, then recovery (R7, R9)
        run_cycle(1, 8'h00, 0, 4'd5, 3'd1, 3'd0, 0, 0);
        run_cycle(1, 8'h00, 0, 4'd5, 3'd1, 3'd0, 1, 0);
        run_cycle(0, 8'h0f, 0, 4'd5, 3'd4, 3'd0, 0, 0);
        run_cycle(0, 8'hf0, 0, 4'd14, 3'd6, 3'd7, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule